// File: doc/BRIEF.md
# Logical ALU with Packed Flag Register

This block holds an 8-bit accumulator and an 8-bit flag register. On each clock edge it can combine the accumulator with an operand byte using a bitwise AND, OR or XOR, then write the result back into the accumulator. The same edge also updates the flags.

The flags follow the classic 8-bit convention for logical operations. Sign and two spare bits are copied from the result. Zero reports an all-clear result. The parity/overflow bit reports even parity. Half-carry is set only by AND, and subtract and carry are always cleared.

The flag register can also be written as a whole from a byte and is always visible as a packed byte on an output. This lets a surrounding core save and restore the accumulator-flag pair on a stack. A logical operation and a flag load may arrive in the same cycle. In that case the logical operation wins.

Top module: `lalu_top`

## Requirements
- R1: With opSel = 2'b01 (AND), on the next clock edge acc becomes the old acc AND operand.
- R2: With opSel = 2'b10 (OR), on the next clock edge acc becomes the old acc OR operand.
- R3: With opSel = 2'b11 (XOR), on the next clock edge acc becomes the old acc XOR operand.
- R4: After any logical operation, flags bit 7 (sign), bit 5 and bit 3 equal the same bits of the new acc.
- R5: After any logical operation, flags bit 6 (zero) is 1 exactly when the new acc is 8'h00.
- R6: After any logical operation, flags bit 2 (parity/overflow) is 1 exactly when the new acc holds an even number of ones.
- R7: After AND, flags bit 4 (half-carry) is 1; after OR or XOR it is 0. After any of the three, flags bit 1 (subtract) and bit 0 (carry) are 0.
- R8: With opSel = 2'b00 and flagLoad high, flags becomes flagIn bit for bit on the next edge (S=7, Z=6, bit5=5, H=4, bit3=3, P/V=2, N=1, C=0), and acc is unchanged.
- R9: When opSel is non-zero and flagLoad is high in the same cycle, the logical operation sets acc and flags and flagIn is ignored.
- R10: With opSel = 2'b00 and flagLoad low, acc and flags hold their values.
- R11: While rstN is low, acc and flags are cleared to 8'h00 on the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous active-low reset |
| opSel | input | 2 | 00 none, 01 AND, 10 OR, 11 XOR |
| operand | input | 8 | Second operand byte |
| flagLoad | input | 1 | Strobe to load the flag register from flagIn |
| flagIn | input | 8 | Byte to load into the flag register |
| acc | output | 8 | Accumulator |
| flags | output | 8 | Packed flag register |

## Verification
The bench drives results whose flags are easy to get wrong:
- A zero result. A design with an inverted zero sense would show the zero flag clear.
- Results with odd and with even numbers of ones. A design that computes odd parity would flip bit 2 on every one of them.
- A change from AND to OR or XOR. A design that forgets to drop half-carry would keep bit 4 set after the switch.
- A flag load presented together with an operation. If the priority were reversed, the loaded byte would appear on flags instead of the operation's flags.
- Loads of 8'hFF, 8'hA5 and 8'h5A. A swapped or dropped bit in the packed layout would show up in the read-back byte.

// File: rtl/lalu_pkg.sv
package lalu_pkg;

  localparam int DATA_W = 8;
  localparam int OP_W   = 2;

  // flag bit positions in the packed byte
  localparam int F_C  = 0;
  localparam int F_N  = 1;
  localparam int F_PV = 2;
  localparam int F_B3 = 3;
  localparam int F_H  = 4;
  localparam int F_B5 = 5;
  localparam int F_Z  = 6;
  localparam int F_S  = 7;

  typedef enum logic [OP_W-1:0] {
    OP_NONE = 2'b00,
    OP_AND  = 2'b01,
    OP_OR   = 2'b10,
    OP_XOR  = 2'b11
  } logOp_e;

  typedef struct packed {
    logic   accWe;
    logic   flagOpWe;
    logic   flagLoadWe;
    logOp_e op;
  } ctrl_t;

endpackage

// File: rtl/lalu_ctrl.sv
module lalu_ctrl
  import lalu_pkg::*;
(
  input  logic [OP_W-1:0] opSel,
  input  logic            flagLoad,
  output ctrl_t           ctrl
);

  logOp_e opDec;

  always_comb begin
    opDec = logOp_e'(opSel);
    ctrl = '0;
    ctrl.op = opDec;
    if (opDec != OP_NONE) begin
      // operation wins over a simultaneous flag load
      ctrl.accWe    = 1'b1;
      ctrl.flagOpWe = 1'b1;
    end else if (flagLoad) begin
      ctrl.flagLoadWe = 1'b1;
    end
  end

endmodule

// File: rtl/lalu_datapath.sv
module lalu_datapath
  import lalu_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_t             ctrl,
  input  logic [DATA_W-1:0] operand,
  input  logic [DATA_W-1:0] flagIn,
  output logic [DATA_W-1:0] accQ,
  output logic [DATA_W-1:0] flagQ
);

  logic [DATA_W-1:0] result;
  logic [DATA_W-1:0] opFlags;

  always_comb begin
    unique case (ctrl.op)
      OP_AND:  result = accQ & operand;
      OP_OR:   result = accQ | operand;
      OP_XOR:  result = accQ ^ operand;
      default: result = accQ;
    endcase
  end

  always_comb begin
    opFlags        = '0;
    opFlags[F_S]   = result[DATA_W-1];
    opFlags[F_Z]   = (result == '0);
    opFlags[F_B5]  = result[5];
    opFlags[F_H]   = (ctrl.op == OP_AND);
    opFlags[F_B3]  = result[3];
    opFlags[F_PV]  = ~^result;
    opFlags[F_N]   = 1'b0;
    opFlags[F_C]   = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      accQ  <= '0;
      flagQ <= '0;
    end else begin
      if (ctrl.accWe) accQ <= result;
      if (ctrl.flagOpWe)        flagQ <= opFlags;
      else if (ctrl.flagLoadWe) flagQ <= flagIn;
    end
  end

endmodule

// File: rtl/lalu_top.sv
module lalu_top
  import lalu_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [1:0]  opSel,
  input  logic [7:0]  operand,
  input  logic        flagLoad,
  input  logic [7:0]  flagIn,
  output logic [7:0]  acc,
  output logic [7:0]  flags
);

  ctrl_t ctrl;

  lalu_ctrl u_ctrl (
    .opSel    (opSel),
    .flagLoad (flagLoad),
    .ctrl     (ctrl)
  );

  lalu_datapath u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ctrl    (ctrl),
    .operand (operand),
    .flagIn  (flagIn),
    .accQ    (acc),
    .flagQ   (flags)
  );

endmodule

// File: rtl/lalu_chk.sv
module lalu_chk
  import lalu_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic [1:0] opSel,
  input logic [7:0] operand,
  input logic       flagLoad,
  input logic [7:0] flagIn,
  input logic [7:0] acc,
  input logic [7:0] flags
);

  AST_AND_RESULT: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(opSel) == OP_AND) |-> acc == ($past(acc) & $past(operand))); // R1
  AST_OR_RESULT: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(opSel) == OP_OR) |-> acc == ($past(acc) | $past(operand))); // R2
  AST_XOR_RESULT: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(opSel) == OP_XOR) |-> acc == ($past(acc) ^ $past(operand))); // R3
  AST_COPY_BITS: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(opSel) != OP_NONE) |->
      (flags[F_S] == acc[7] && flags[F_B5] == acc[5] && flags[F_B3] == acc[3])); // R4
  AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(opSel) != OP_NONE) |-> flags[F_Z] == (acc == 8'h00)); // R5
  AST_EVEN_PARITY: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(opSel) != OP_NONE) |-> flags[F_PV] == ($countones(acc) % 2 == 0)); // R6
  AST_HALF_SUB_CARRY: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(opSel) != OP_NONE) |->
      (flags[F_H] == ($past(opSel) == OP_AND) && !flags[F_N] && !flags[F_C])); // R7
  AST_FLAG_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(opSel) == OP_NONE && $past(flagLoad)) |->
      (flags == $past(flagIn) && $stable(acc))); // R8
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(opSel) == OP_NONE && !$past(flagLoad)) |->
      ($stable(acc) && $stable(flags))); // R10
  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rstN |=> (acc == 8'h00 && flags == 8'h00)); // R11

endmodule

bind lalu_top lalu_chk u_chk (.*);

// File: tb/lalu_top_tb.sv
`timescale 1ns/1ps
module lalu_top_tb;

  typedef struct {
    logic [7:0] expAcc;
    logic [7:0] expFlags;
    string      tag;
  } item_t;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] opSel = 2'b00;
  logic [7:0] operand = 8'h00;
  logic       flagLoad = 1'b0;
  logic [7:0] flagIn = 8'h00;
  logic [7:0] acc;
  logic [7:0] flags;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  item_t sbq[$];
  logic [7:0] mAcc = 8'h00;
  logic [7:0] mFlags = 8'h00;

  always #2 clk = ~clk;

  lalu_top u_dut (
    .clk(clk), .rstN(rstN), .opSel(opSel), .operand(operand),
    .flagLoad(flagLoad), .flagIn(flagIn), .acc(acc), .flags(flags)
  );

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got acc/flags %h expected %h", tag, got, exp);
    end
  endtask

  // driver: applies one cycle of stimulus and pushes the model's expectation
  task automatic drive(input logic [1:0] op, input logic [7:0] opnd,
                       input logic ld, input logic [7:0] fin, input string tag);
    logic [7:0] r;
    item_t it;
    @(negedge clk);
    opSel = op; operand = opnd; flagLoad = ld; flagIn = fin;
    if (op != 2'b00) begin
      case (op)
        2'b01:   r = mAcc & opnd;
        2'b10:   r = mAcc | opnd;
        default: r = mAcc ^ opnd;
      endcase
      mAcc = r;
      mFlags = {r[7], (r == 8'h00), r[5], (op == 2'b01), r[3],
                ($countones(r) % 2 == 0), 1'b0, 1'b0};
    end else if (ld) begin
      mFlags = fin;
    end
    it.expAcc = mAcc; it.expFlags = mFlags; it.tag = tag;
    sbq.push_back(it);
  endtask

  // monitor: compares one item per clock after the edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sbq.size() > 0) begin
        item_t it;
        it = sbq.pop_front();
        check(it.tag, {acc, flags}, {it.expAcc, it.expFlags});
      end
    end
  end

  initial begin
    #20000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got hang expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R11 reset clears", {acc, flags}, 16'h0000);
    rstN = 1'b1;
    drive(2'b00, 8'h00, 1'b1, 8'hFF, "R8 load all ones");
    drive(2'b00, 8'h00, 1'b1, 8'hA5, "R8 load A5");
    drive(2'b00, 8'h00, 1'b1, 8'h5A, "R8 load 5A");
    drive(2'b00, 8'h33, 1'b0, 8'hFF, "R10 idle holds");
    drive(2'b01, 8'hFF, 1'b0, 8'h00, "R1 R5 AND zero result");
    drive(2'b10, 8'h96, 1'b0, 8'h00, "R2 R4 R6 OR even parity");
    drive(2'b11, 8'hFE, 1'b0, 8'h00, "R3 R6 R7 XOR odd parity");
    drive(2'b01, 8'hEF, 1'b0, 8'h00, "R1 R7 AND half carry");
    drive(2'b10, 8'h28, 1'b0, 8'h00, "R2 R4 R7 OR bits 5 3");
    drive(2'b01, 8'hFF, 1'b1, 8'h00, "R9 op beats load AND");
    drive(2'b11, 8'h6C, 1'b1, 8'hFF, "R9 op beats load XOR");
    drive(2'b11, 8'h00, 1'b0, 8'h00, "R3 R5 XOR nonzero");
    drive(2'b00, 8'hFF, 1'b0, 8'h00, "R10 idle after op");
    drive(2'b01, 8'h00, 1'b0, 8'h00, "R1 R5 R6 AND to zero");
    drive(2'b00, 8'h00, 1'b1, 8'h01, "R8 load carry only");
    drive(2'b10, 8'h80, 1'b0, 8'h00, "R2 R4 sign set");
    @(negedge clk);
    opSel = 2'b00; flagLoad = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    check("R11 reset after activity", {acc, flags}, 16'h0000);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule